// File: doc/BRIEF.md
# Memory Upset Pattern Tester

This block drives an external synchronous memory while it sits in a particle beam and counts the bits that come back wrong. It generates a data pattern, writes it through a plain address / write-data / write-enable / read-enable port, reads the words back and compares each one with the value it should hold. Every differing bit adds one to a saturating error counter. A word with two or more bad bits also adds one to a separate multi-bit counter. The address of the latest failing word is kept, and a bit that fails again on the next check of the same word is flagged as a likely stuck cell.

There are two run styles. In static mode the tester fills the array once and then waits. Each `runEnd` strobe starts one read-back pass over the array, so the memory is verified only after exposure. In dynamic mode the tester keeps cycling through the array for as long as the run lasts. Each address gets a write cycle followed by a read cycle. Both styles use a programmable last address, `depthLast`. A run is started by a `start` pulse and ended by `stopRun`.

Top module: `mem_upset_tester`

## Requirements
- R1: After reset the tester is idle (`busy`=0), asserts neither `memWe` nor `memRe`, and holds both counters and `lastErrAddr` at zero. `stuckFlag` and `patRefused` are clear.
- R2: Static start: the tester writes each address from 0 to `depthLast` exactly once and then issues no read until `runEnd`. Each `runEnd` then triggers one read pass over the same addresses.
- R3: A start in static mode with `patSel`=3 (toggle) is refused. `patRefused` goes to 1, no run begins and nothing is written. The next accepted start clears `patRefused`.
- R4: `patSel` encodes the pattern: 0 all zeros, 1 all ones, 2 checkerboard, 3 toggle. The checkerboard word is 0x55.. (even bit positions set) at even addresses and 0xAA.. at odd addresses.
- R5: With the toggle pattern in a dynamic run, `memWrData` is all zeros in the first cycle and inverts on every clock after that.
- R6: In a dynamic run each address gets one cycle with `memWe` and then one cycle with `memRe` at the same address. After `depthLast` the address wraps to 0, and `memWe` and `memRe` are never high together.
- R7: Read data is taken in the cycle after `memRe`. The error counter grows by the number of bits that differ from the expected word.
- R8: The error counter saturates at all ones instead of wrapping. An accepted start clears both counters.
- R9: Each compared word with two or more differing bits adds exactly one to `multiCount`.
- R10: `lastErrAddr` holds the address of the most recent compare that had any differing bit.
- R11: When the same bit of the same address fails on two consecutive compares of that address within one run, `stuckFlag` sets and stays set until the next accepted start. `stuckAddr` takes that address.
- R12: `stopRun` returns the tester to idle from any state. A `start` while a run is active is ignored and does not clear the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: begin a run with the current mode, pattern and depth |
| stopRun | input | 1 | Pulse: abandon the run and go idle |
| runEnd | input | 1 | Pulse: in static mode, start one read-back pass |
| dynMode | input | 1 | 1 selects dynamic mode, 0 static mode |
| patSel | input | 2 | Pattern code (see R4) |
| depthLast | input | ADDR_W | Last address used by the run |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | DATA_W | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable; data is returned on the next cycle |
| memRdData | input | DATA_W | Memory read data |
| busy | output | 1 | A run is active |
| patRefused | output | 1 | The last start was refused |
| errCount | output | CNT_W | Saturating count of upset bits |
| multiCount | output | CNT_W | Saturating count of words with two or more upset bits |
| lastErrAddr | output | ADDR_W | Address of the latest failing word |
| stuckFlag | output | 1 | Sticky flag for a repeated failure of the same bit |
| stuckAddr | output | ADDR_W | Address of the latest repeated failure |

## Verification
The bench injects faults in the memory model that line up with particular patterns and passes. A single-bit fault is checked for a one-pass count without a stuck flag and then a stuck flag on the second pass; a tester that flagged on the first failure, or kept no per-word history, would get this wrong. A two-bit fault in one word must move the multi-bit counter by exactly one. A faulty memory returning every bit inverted pushes a narrow counter past its top; a counter that wraps would show a small value there instead of all ones. The bench also covers a toggle start refused in static mode, a start during an active run, and the dynamic address wrap with its alternating data. A wrong design would in turn write memory anyway, clear the counts, or skip or repeat an address at the wrap.

// File: rtl/upset_tester_pkg.sv
package upset_tester_pkg;

  typedef enum logic [1:0] {
    PAT_ZEROS  = 2'd0,
    PAT_ONES   = 2'd1,
    PAT_CHECK  = 2'd2,
    PAT_TOGGLE = 2'd3
  } pat_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // accepted start: latch config, clear counters and history
    logic write;    // write cycle at current address
    logic read;     // read cycle at current address
    logic running;  // a run is active
  } strobe_t;

endpackage

// File: rtl/upset_ctrl.sv
module upset_ctrl
  import upset_tester_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stopRun,
  input  logic              runEnd,
  input  logic              dynMode,
  input  logic [1:0]        patSel,
  input  logic [ADDR_W-1:0] depthLast,
  output strobe_t           ctl,
  output logic [ADDR_W-1:0] addr,
  output logic              patRefused
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ARMED, S_VERIFY, S_DWR, S_DRD
  } state_e;

  state_e            state;
  logic [ADDR_W-1:0] depthQ;
  logic              refuse;
  logic              atEnd;

  assign refuse = !dynMode && (patSel == PAT_TOGGLE);
  assign atEnd  = (addr == depthQ);

  assign ctl.clear   = (state == S_IDLE) && start && !refuse;
  assign ctl.write   = (state == S_LOAD) || (state == S_DWR);
  assign ctl.read    = (state == S_VERIFY) || (state == S_DRD);
  assign ctl.running = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr       <= '0;
      depthQ     <= '0;
      patRefused <= 1'b0;
    end else if (stopRun && state != S_IDLE) begin
      state <= S_IDLE;
      addr  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            patRefused <= refuse;
            if (!refuse) begin
              depthQ <= depthLast;
              addr   <= '0;
              state  <= dynMode ? S_DWR : S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (atEnd) begin
            addr  <= '0;
            state <= S_ARMED;
          end else begin
            addr <= addr + ADDR_W'(1);
          end
        end
        S_ARMED: begin
          if (runEnd) state <= S_VERIFY;
        end
        S_VERIFY: begin
          if (atEnd) begin
            addr  <= '0;
            state <= S_ARMED;
          end else begin
            addr <= addr + ADDR_W'(1);
          end
        end
        S_DWR: state <= S_DRD;
        S_DRD: begin
          state <= S_DWR;
          addr  <= atEnd ? '0 : addr + ADDR_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // refused toggle start leaves the tester idle with the flag raised
  assert_refuse_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && refuse) |=> (state == S_IDLE && patRefused));

  // dynamic write is followed by a read of the same address
  assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DWR && !stopRun) |=> (ctl.read && addr == $past(addr)));

  // address wraps to zero after the last read of a pass
  assert_dyn_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRD && atEnd && !stopRun) |=> (addr == '0 && ctl.write));

  assert_addr_in_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (addr <= depthQ));

  // static array is not read while waiting for the run end
  assert_armed_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED && !runEnd) |=> (!ctl.read));

  assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stopRun && state != S_IDLE) |=> (!ctl.running));

endmodule

// File: rtl/upset_datapath.sv
module upset_datapath
  import upset_tester_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        patSel,
  input  logic              dynMode,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic [CNT_W-1:0]  errCount,
  output logic [CNT_W-1:0]  multiCount,
  output logic [ADDR_W-1:0] lastErrAddr,
  output logic              stuckFlag,
  output logic [ADDR_W-1:0] stuckAddr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(DATA_W + 1);

  pat_e              patQ;
  logic              dynQ;
  logic              togglePh;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] wrWord;
  logic [DATA_W-1:0] lastWr;
  logic              cmpValid;
  logic [ADDR_W-1:0] cmpAddr;
  logic [DATA_W-1:0] cmpExp;
  logic [DATA_W-1:0] failMask;
  logic [CW-1:0]     failCnt;
  logic [CNT_W:0]    errSum;
  logic              multiHit;
  logic              stuckHit;
  logic [DATA_W-1:0] prevFail [DEPTH];

  // fixed pattern word for the current address
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      case (patQ)
        PAT_ONES:  statWord[i] = 1'b1;
        PAT_CHECK: statWord[i] = ((i % 2) == 0) ^ addr[0];
        default:   statWord[i] = 1'b0;
      endcase
    end
  end

  assign wrWord    = (patQ == PAT_TOGGLE) ? {DATA_W{togglePh}} : statWord;
  assign memWrData = wrWord;

  // compare of the word returned for the previous read
  assign failMask = cmpValid ? (memRdData ^ cmpExp) : '0;

  always_comb begin
    failCnt = '0;
    for (int i = 0; i < DATA_W; i++) failCnt = failCnt + CW'(failMask[i]);
  end

  assign errSum   = {1'b0, errCount} + (CNT_W + 1)'(failCnt);
  assign multiHit = (failCnt > CW'(1));
  assign stuckHit = |(failMask & prevFail[cmpAddr]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      patQ        <= PAT_ZEROS;
      dynQ        <= 1'b0;
      togglePh    <= 1'b0;
      lastWr      <= '0;
      cmpValid    <= 1'b0;
      cmpAddr     <= '0;
      cmpExp      <= '0;
      errCount    <= '0;
      multiCount  <= '0;
      lastErrAddr <= '0;
      stuckFlag   <= 1'b0;
      stuckAddr   <= '0;
      for (int a = 0; a < DEPTH; a++) prevFail[a] <= '0;
    end else if (ctl.clear) begin
      patQ        <= pat_e'(patSel);
      dynQ        <= dynMode;
      togglePh    <= 1'b0;
      cmpValid    <= 1'b0;
      errCount    <= '0;
      multiCount  <= '0;
      lastErrAddr <= '0;
      stuckFlag   <= 1'b0;
      stuckAddr   <= '0;
      for (int a = 0; a < DEPTH; a++) prevFail[a] <= '0;
    end else begin
      if (ctl.running) togglePh <= ~togglePh;
      if (ctl.write)   lastWr   <= wrWord;
      cmpValid <= ctl.read;
      cmpAddr  <= addr;
      cmpExp   <= dynQ ? lastWr : statWord;
      if (cmpValid) begin
        prevFail[cmpAddr] <= failMask;
        if (|failMask) begin
          lastErrAddr <= cmpAddr;
          errCount    <= errSum[CNT_W] ? '1 : errSum[CNT_W-1:0];
        end
        if (multiHit && multiCount != '1) multiCount <= multiCount + CNT_W'(1);
        if (stuckHit) begin
          stuckFlag <= 1'b1;
          stuckAddr <= cmpAddr;
        end
      end
    end
  end

  assert_toggle_inverts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.running && $past(ctl.running) && dynQ && patQ == PAT_TOGGLE)
      |-> (memWrData == ~$past(memWrData)));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clear) |=> (errCount >= $past(errCount) && multiCount >= $past(multiCount)));

  assert_clear_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (errCount == '0 && multiCount == '0));

  assert_stuck_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stuckFlag && !ctl.clear) |=> stuckFlag);

  assert_multi_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clear) |=> (multiCount - $past(multiCount) <= CNT_W'(1)));

endmodule

// File: rtl/mem_upset_tester.sv
module mem_upset_tester
  import upset_tester_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stopRun,
  input  logic              runEnd,
  input  logic              dynMode,
  input  logic [1:0]        patSel,
  input  logic [ADDR_W-1:0] depthLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              patRefused,
  output logic [CNT_W-1:0]  errCount,
  output logic [CNT_W-1:0]  multiCount,
  output logic [ADDR_W-1:0] lastErrAddr,
  output logic              stuckFlag,
  output logic [ADDR_W-1:0] stuckAddr
);

  strobe_t           ctl;
  logic [ADDR_W-1:0] addr;

  upset_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stopRun    (stopRun),
    .runEnd     (runEnd),
    .dynMode    (dynMode),
    .patSel     (patSel),
    .depthLast  (depthLast),
    .ctl        (ctl),
    .addr       (addr),
    .patRefused (patRefused)
  );

  upset_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .addr        (addr),
    .patSel      (patSel),
    .dynMode     (dynMode),
    .memRdData   (memRdData),
    .memWrData   (memWrData),
    .errCount    (errCount),
    .multiCount  (multiCount),
    .lastErrAddr (lastErrAddr),
    .stuckFlag   (stuckFlag),
    .stuckAddr   (stuckAddr)
  );

  assign memAddr = addr;
  assign memWe   = ctl.write;
  assign memRe   = ctl.read;
  assign busy    = ctl.running;

endmodule

// File: tb/sim_mem_upset_tester.sv
`timescale 1ns/1ps
module sim_mem_upset_tester;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, stopRun = 1'b0, runEnd = 1'b0, dynMode = 1'b0;
  logic [1:0]    patSel = 2'd0;
  logic [AW-1:0] depthLast = '0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData;
  logic          memWe, memRe;
  logic [DW-1:0] memRdData = '0;
  logic          busy, patRefused, stuckFlag;
  logic [CW-1:0] errCount, multiCount;
  logic [AW-1:0] lastErrAddr, stuckAddr;

  int total = 0;
  int bad = 0;
  int weCnt = 0;
  int reCnt = 0;

  logic [DW-1:0] mem      [16];
  logic [DW-1:0] faultXor [16];

  always #5 clk = ~clk;

  mem_upset_tester #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stopRun(stopRun), .runEnd(runEnd),
    .dynMode(dynMode), .patSel(patSel), .depthLast(depthLast),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .memRe(memRe),
    .memRdData(memRdData), .busy(busy), .patRefused(patRefused),
    .errCount(errCount), .multiCount(multiCount), .lastErrAddr(lastErrAddr),
    .stuckFlag(stuckFlag), .stuckAddr(stuckAddr)
  );

  // synchronous memory model with a fault mask applied on read
  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr] <= memWrData;
      weCnt <= weCnt + 1;
    end
    if (memRe) begin
      memRdData <= mem[memAddr] ^ faultXor[memAddr];
      reCnt <= reCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFaults();
    for (int i = 0; i < 16; i++) faultXor[i] = '0;
  endtask

  task automatic doStart(input logic dyn, input logic [1:0] pat, input logic [AW-1:0] last);
    dynMode = dyn; patSel = pat; depthLast = last; start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic pulseRunEnd();
    runEnd = 1'b1; tick(1); runEnd = 1'b0;
  endtask

  task automatic pulseStop();
    stopRun = 1'b1; tick(1); stopRun = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 we/re", {memWe, memRe}, 0);
    chk("R1 errCount", errCount, 0);
    chk("R1 multiCount", multiCount, 0);
    chk("R1 flags", {stuckFlag, patRefused}, 0);
    chk("R1 lastErrAddr", lastErrAddr, 0);
  endtask

  task automatic testStaticOnes();
    int w0, r0;
    w0 = weCnt; r0 = reCnt;
    doStart(1'b0, 2'd1, 4'd15);
    tick(25);
    chk("R2 writes in load", weCnt - w0, 16);
    chk("R2 no reads before runEnd", reCnt - r0, 0);
    for (int i = 0; i < 16; i++) chk("R4 ones word", mem[i], 8'hFF);
    pulseRunEnd();
    tick(20);
    chk("R2 reads in verify", reCnt - r0, 16);
    chk("R7 no errors", errCount, 0);
    pulseStop();
    chk("R12 idle after stop", busy, 0);
  endtask

  task automatic testStaticCheck();
    doStart(1'b0, 2'd2, 4'd15);
    tick(20);
    chk("R4 checker even", mem[0], 8'h55);
    chk("R4 checker odd", mem[1], 8'hAA);
    chk("R4 checker last", mem[15], 8'hAA);
    faultXor[2] = 8'h10;
    faultXor[5] = 8'h03;
    pulseRunEnd();
    tick(20);
    chk("R7 bit count", errCount, 3);
    chk("R9 multi count", multiCount, 1);
    chk("R10 last address", lastErrAddr, 5);
    chk("R11 no stuck after one pass", stuckFlag, 0);
    pulseStop();
    clearFaults();
  endtask

  task automatic testStaticStuck();
    int w0, r0;
    doStart(1'b0, 2'd0, 4'd15);
    tick(20);
    for (int i = 0; i < 16; i++) chk("R4 zeros word", mem[i], 8'h00);
    faultXor[9] = 8'h01;
    pulseRunEnd();
    tick(20);
    chk("R7 single fault", errCount, 1);
    chk("R11 not stuck after first fail", stuckFlag, 0);
    w0 = weCnt; r0 = reCnt;
    doStart(1'b1, 2'd1, 4'd3);
    tick(5);
    chk("R12 start while busy keeps count", errCount, 1);
    chk("R12 start while busy no access", (weCnt - w0) + (reCnt - r0), 0);
    pulseRunEnd();
    tick(20);
    chk("R7 second pass", errCount, 2);
    chk("R11 stuck flag", stuckFlag, 1);
    chk("R11 stuck address", stuckAddr, 9);
    pulseStop();
    chk("R12 stop from armed", busy, 0);
    clearFaults();
  endtask

  task automatic testRefuse();
    int w0;
    w0 = weCnt;
    doStart(1'b0, 2'd3, 4'd7);
    tick(10);
    chk("R3 refused flag", patRefused, 1);
    chk("R3 stays idle", busy, 0);
    chk("R3 nothing written", weCnt - w0, 0);
  endtask

  task automatic testDynToggle();
    doStart(1'b1, 2'd3, 4'd3);
    chk("R3 flag cleared by accepted start", patRefused, 0);
    for (int k = 0; k < 10; k++) begin
      chk("R6 address sequence", memAddr, (k / 2) % 4);
      chk("R6 write/read alternation", {memWe, memRe}, (k % 2 == 0) ? 2'b10 : 2'b01);
      chk("R5 toggle data", memWrData, (k % 2 == 0) ? 8'h00 : 8'hFF);
      tick(1);
    end
    tick(20);
    chk("R7 no errors dynamic", errCount, 0);
    pulseStop();
  endtask

  task automatic testDynStuck();
    doStart(1'b1, 2'd0, 4'd3);
    faultXor[2] = 8'h80;
    tick(40);
    chk("R11 dynamic stuck flag", stuckFlag, 1);
    chk("R11 dynamic stuck address", stuckAddr, 2);
    chk("R10 dynamic last address", lastErrAddr, 2);
    chk("R9 single-bit words not multi", multiCount, 0);
    chk("R7 repeated fails counted", errCount >= 2, 1);
    pulseStop();
    clearFaults();
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 16; i++) faultXor[i] = 8'hFF;
    doStart(1'b1, 2'd1, 4'd15);
    tick(120);
    chk("R8 saturated count", errCount, 8'hFF);
    chk("R9 multi per word", multiCount > 50 && multiCount < 62, 1);
    pulseStop();
    clearFaults();
    doStart(1'b1, 2'd1, 4'd15);
    chk("R8 cleared by start", errCount, 0);
    chk("R8 multi cleared by start", multiCount, 0);
    pulseStop();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) faultXor[i] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    testReset();
    testStaticOnes();
    testStaticCheck();
    testStaticStuck();
    testRefuse();
    testDynToggle();
    testDynStuck();
    testSaturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule